// File: doc/BRIEF.md
# Precise Trap Collector for a Five-Stage In-Order Pipeline

This block collects the fault strobes that the stages of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) raise and picks the one to take. Faults appear out of program order: a younger instruction in fetch can fault in the same cycle as an older one in memory, or even before it. The block therefore records a pending flag and a cause code with each instruction and moves that record down the pipeline alongside it. It reports a trap only when the faulting instruction becomes the oldest one, in write-back. Because of this, traps always come out in program order.

When the write-back instruction carries a pending fault, or an enabled external interrupt is attached to it, the block raises a one-cycle flush to all stages. In that same cycle it drives the cause code and the PC of that instruction, and it blocks the architectural writes of that instruction and of every younger one. A memory-stage instruction that has recorded a fault has its memory write blocked at once, so a restartable fault leaves no side effect. The pipeline is assumed to advance every cycle. A stall appears as a bubble, which means a cleared valid bit.

Top module: `trap_collector`

## Requirements
- R1: While reset is asserted, and on an empty pipeline afterwards, `flush`, `mem_wr_kill` and `wb_wr_kill` are 0, and `exc_cause` and `exc_pc` are 0.
- R2: The cause codes are: 0 none, 1 fetch page fault, 2 fetch misaligned, 3 fetch protection, 4 illegal opcode, 5 arithmetic, 6 data page fault, 7 data misaligned, 8 data protection, 9 external interrupt. Fetch strobes `if_fault[0..2]` map to 1..2..3. `id_fault` maps to 4. `ex_fault` maps to 5. Memory strobes `mem_fault[0..2]` map to 6..7..8.
- R3: When several strobes of one stage rise together for one instruction, the lowest-numbered bit wins.
- R4: Once an instruction has a recorded fault, later-stage strobes for that instruction are ignored, and its first cause is the one reported.
- R5: A trap is taken only in the cycle its instruction is valid in write-back, which is four cycles after it entered fetch. `flush` lasts exactly one cycle.
- R6: Traps are reported in program order. An older instruction's fault wins over a younger instruction's fault, even one raised in an earlier cycle.
- R7: A stage whose valid bit is 0 never records or reports a fault.
- R8: `mem_wr_kill` is 1 in any cycle where the memory-stage instruction has a recorded fault, and in every flush cycle.
- R9: `wb_wr_kill` is 1 exactly in flush cycles.
- R10: In a flush cycle, `exc_pc` equals `wb_pc`.
- R11: The interrupt is taken only when `irq_req` and `irq_en` are both 1 and write-back holds a valid instruction, with cause 9. If that instruction also has a recorded fault, the fault cause is reported instead.
- R12: A flush discards every record carried by younger instructions, so none of them is reported later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_valid | input | 5 | Valid bits: bit 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back |
| wb_pc | input | PC_W | PC of the write-back instruction |
| if_fault | input | 3 | Fetch strobes: page fault, misaligned, protection |
| id_fault | input | 1 | Illegal opcode strobe |
| ex_fault | input | 1 | Arithmetic fault strobe |
| mem_fault | input | 3 | Memory strobes: page fault, misaligned, protection |
| irq_req | input | 1 | External interrupt request level |
| irq_en | input | 1 | Interrupt enable mask bit |
| flush | output | 1 | Flush all stages this cycle |
| exc_cause | output | 4 | Cause code of the trap taken, else 0 |
| exc_pc | output | PC_W | PC of the trapping instruction, else 0 |
| mem_wr_kill | output | 1 | Block the memory-stage write |
| wb_wr_kill | output | 1 | Block the write-back register write |

## Verification
The assertions assume that the pipeline moves one stage per clock and obeys a flush. After a flush, decode through write-back are empty in the next cycle, so the one-cycle flush rule depends on write-back being a bubble then. The bench drives its own pipeline model that shifts valid bits and PCs every cycle and clears the older stages after each flush. Fault strobes and interrupt levels are random, and only the valid bits must follow this pipeline discipline. Directed cases cover intra-stage priority, suppression of later causes, reversed detection order, bubbles and the interrupt mask.

// File: rtl/trap_pkg.sv
// Package: cause codes and per-stage constants for the trap collector.
// Assumes five stages indexed 0 (fetch) to 4 (write-back).
package trap_pkg;

    typedef enum logic [3:0] {
        CAUSE_NONE        = 4'd0,
        CAUSE_FETCH_PAGE  = 4'd1,
        CAUSE_FETCH_ALIGN = 4'd2,
        CAUSE_FETCH_PROT  = 4'd3,
        CAUSE_BAD_OP      = 4'd4,
        CAUSE_ARITH       = 4'd5,
        CAUSE_DATA_PAGE   = 4'd6,
        CAUSE_DATA_ALIGN  = 4'd7,
        CAUSE_DATA_PROT   = 4'd8,
        CAUSE_IRQ         = 4'd9
    } cause_e;

    localparam int N_STAGE  = 5;
    localparam int WB_STAGE = N_STAGE - 1;
    localparam int MEM_STAGE = N_STAGE - 2;

    // Number of fault strobes a stage owns (write-back owns none).
    function automatic int stage_strobes(input int s);
        case (s)
            0:       return 3;
            1:       return 1;
            2:       return 1;
            3:       return 3;
            default: return 0;
        endcase
    endfunction

    // Cause code of the lowest strobe bit of a stage.
    function automatic logic [3:0] stage_base(input int s);
        case (s)
            0:       return 4'(CAUSE_FETCH_PAGE);
            1:       return 4'(CAUSE_BAD_OP);
            2:       return 4'(CAUSE_ARITH);
            3:       return 4'(CAUSE_DATA_PAGE);
            default: return 4'(CAUSE_NONE);
        endcase
    endfunction

endpackage

// File: rtl/trap_encoder.sv
// Module: priority encoder for one stage's fault strobes.
// Lowest-numbered strobe wins; cause = BASE + bit index.
// Assumes BASE + W - 1 stays within the cause code range.
module trap_encoder
    import trap_pkg::*;
#(
    parameter int          W    = 3,
    parameter logic [3:0]  BASE = 4'd1
) (
    input  logic [W-1:0] strobe,
    output logic         hit,
    output cause_e       cause
);

    // Select the lowest active strobe and form its cause code.
    always_comb begin
        hit   = |strobe;
        cause = CAUSE_NONE;
        for (int i = W - 1; i >= 0; i--) begin
            if (strobe[i]) begin
                cause = cause_e'(BASE + 4'(i));
            end
        end
    end

endmodule

// File: rtl/trap_slot.sv
// Module: one pipeline-latch record of the fault state carried with an
// instruction (pending flag and first cause). Cleared by reset or flush.
// Assumes the pipeline advances every clock.
module trap_slot
    import trap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   flush,
    input  logic   in_pend,
    input  cause_e in_cause,
    output logic   pend,
    output cause_e cause
);

    // Capture the record of the instruction entering this latch.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pend  <= 1'b0;
            cause <= CAUSE_NONE;
        end else begin
            pend  <= in_pend;
            cause <= in_pend ? in_cause : CAUSE_NONE;
        end
    end

    // R12: a flush leaves no carried record behind.
    assert_slot_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !pend);

endmodule

// File: rtl/trap_commit.sv
// Module: trap decision at write-back. Takes a recorded fault or an
// enabled interrupt on the oldest valid instruction, drives flush, cause,
// PC and the write blocks. Assumes all inputs settle within the cycle.
module trap_commit
    import trap_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wb_valid,
    input  logic            wb_pend,
    input  cause_e          wb_cause,
    input  logic [PC_W-1:0] wb_pc,
    input  logic            mem_pend,
    input  logic            irq_req,
    input  logic            irq_en,
    output logic            flush,
    output logic [3:0]      exc_cause,
    output logic [PC_W-1:0] exc_pc,
    output logic            mem_wr_kill,
    output logic            wb_wr_kill
);

    logic take_fault;
    logic take_irq;

    // Decide whether, and why, the write-back instruction traps.
    always_comb begin
        take_fault  = wb_valid && wb_pend;
        take_irq    = wb_valid && !wb_pend && irq_req && irq_en;
        flush       = take_fault || take_irq;
        exc_cause   = take_fault ? 4'(wb_cause) : (take_irq ? 4'(CAUSE_IRQ) : 4'(CAUSE_NONE));
        exc_pc      = flush ? wb_pc : '0;
        wb_wr_kill  = flush;
        mem_wr_kill = flush || mem_pend;
    end

    // R5: a trap needs a valid write-back instruction.
    assert_take_at_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> wb_valid);

    // R8: a flush blocks the younger memory write too.
    assert_kill_on_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (mem_wr_kill && wb_wr_kill));

    // R11: an interrupt trap needs the request and the mask bit.
    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && exc_cause == 4'(CAUSE_IRQ)) |-> (irq_req && irq_en));

    // R2: a trap always carries a real cause, and none is shown otherwise.
    assert_cause_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (exc_cause != 4'(CAUSE_NONE) && exc_cause <= 4'(CAUSE_IRQ)));

    // R1: no cause or PC without a trap.
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (exc_cause == 4'(CAUSE_NONE) && exc_pc == '0));

endmodule

// File: rtl/trap_collector.sv
// Module: precise trap collector (top). Encodes per-stage strobes, merges
// them with the record each instruction carries (first cause sticks),
// shifts records down the pipeline and commits at write-back.
// Assumes lockstep advance of all stages and bubbles for stalls.
module trap_collector
    import trap_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_STAGE-1:0] stage_valid,
    input  logic [PC_W-1:0]   wb_pc,
    input  logic [2:0]        if_fault,
    input  logic              id_fault,
    input  logic              ex_fault,
    input  logic [2:0]        mem_fault,
    input  logic              irq_req,
    input  logic              irq_en,
    output logic              flush,
    output logic [3:0]        exc_cause,
    output logic [PC_W-1:0]   exc_pc,
    output logic              mem_wr_kill,
    output logic              wb_wr_kill
);

    logic   carry_pend  [N_STAGE];
    cause_e carry_cause [N_STAGE];
    logic   new_hit     [N_STAGE];
    cause_e new_cause   [N_STAGE];
    logic   comb_pend   [N_STAGE];
    cause_e comb_cause  [N_STAGE];

    // Fetch has no older latch: nothing is carried into it.
    assign carry_pend[0]  = 1'b0;
    assign carry_cause[0] = CAUSE_NONE;

    genvar s;
    generate
        for (s = 0; s < N_STAGE; s++) begin : g_stage
            if (s == 0) begin : g_enc
                trap_encoder #(.W(stage_strobes(0)), .BASE(stage_base(0))) u_enc (
                    .strobe(if_fault), .hit(new_hit[s]), .cause(new_cause[s]));
            end else if (s == 1) begin : g_enc
                trap_encoder #(.W(stage_strobes(1)), .BASE(stage_base(1))) u_enc (
                    .strobe(id_fault), .hit(new_hit[s]), .cause(new_cause[s]));
            end else if (s == 2) begin : g_enc
                trap_encoder #(.W(stage_strobes(2)), .BASE(stage_base(2))) u_enc (
                    .strobe(ex_fault), .hit(new_hit[s]), .cause(new_cause[s]));
            end else if (s == MEM_STAGE) begin : g_enc
                trap_encoder #(.W(stage_strobes(3)), .BASE(stage_base(3))) u_enc (
                    .strobe(mem_fault), .hit(new_hit[s]), .cause(new_cause[s]));
            end else begin : g_noenc
                assign new_hit[s]   = 1'b0;
                assign new_cause[s] = CAUSE_NONE;
            end

            // Merge carried record with this stage's check; bubbles report nothing.
            always_comb begin
                comb_pend[s]  = stage_valid[s] && (carry_pend[s] || new_hit[s]);
                comb_cause[s] = carry_pend[s] ? carry_cause[s] : new_cause[s];
            end

            if (s > 0) begin : g_slot
                trap_slot u_slot (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .flush    (flush),
                    .in_pend  (comb_pend[s-1]),
                    .in_cause (comb_cause[s-1]),
                    .pend     (carry_pend[s]),
                    .cause    (carry_cause[s])
                );
            end
        end
    endgenerate

    trap_commit #(.PC_W(PC_W)) u_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .wb_valid    (stage_valid[WB_STAGE]),
        .wb_pend     (comb_pend[WB_STAGE]),
        .wb_cause    (comb_cause[WB_STAGE]),
        .wb_pc       (wb_pc),
        .mem_pend    (comb_pend[MEM_STAGE]),
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .flush       (flush),
        .exc_cause   (exc_cause),
        .exc_pc      (exc_pc),
        .mem_wr_kill (mem_wr_kill),
        .wb_wr_kill  (wb_wr_kill)
    );

    // R7: a memory-stage bubble never blocks a write on its own.
    assert_bubble_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stage_valid[MEM_STAGE] && !flush) |-> !mem_wr_kill);

endmodule

// File: tb/trap_collector_test.sv
module trap_collector_test;
    import trap_pkg::*;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      stage_valid = '0;
    logic [PC_W-1:0] wb_pc = '0;
    logic [2:0]      if_fault = '0;
    logic            id_fault = 1'b0;
    logic            ex_fault = 1'b0;
    logic [2:0]      mem_fault = '0;
    logic            irq_req = 1'b0;
    logic            irq_en = 1'b0;
    logic            flush;
    logic [3:0]      exc_cause;
    logic [PC_W-1:0] exc_pc;
    logic            mem_wr_kill;
    logic            wb_wr_kill;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench pipeline model
    bit         mv [5];
    logic [31:0] mpc [5];
    bit         mp [5];
    logic [3:0] mc [5];
    logic [31:0] next_pc = 32'h1000;
    logic [31:0] o_flush, o_cause, o_pc, o_mk, o_wk;

    always #5 clk = ~clk;

    trap_collector #(.PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n), .stage_valid(stage_valid), .wb_pc(wb_pc),
        .if_fault(if_fault), .id_fault(id_fault), .ex_fault(ex_fault),
        .mem_fault(mem_fault), .irq_req(irq_req), .irq_en(irq_en),
        .flush(flush), .exc_cause(exc_cause), .exc_pc(exc_pc),
        .mem_wr_kill(mem_wr_kill), .wb_wr_kill(wb_wr_kill));

    function automatic logic [3:0] strobe_cause(input int s, input logic [2:0] f);
        case (s)
            0: return f[0] ? 4'd1 : f[1] ? 4'd2 : f[2] ? 4'd3 : 4'd0;
            1: return f[0] ? 4'd4 : 4'd0;
            2: return f[0] ? 4'd5 : 4'd0;
            3: return f[0] ? 4'd6 : f[1] ? 4'd7 : f[2] ? 4'd8 : 4'd0;
            default: return 4'd0;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One pipeline cycle: drive, compare against model, advance model.
    task automatic step(input bit nv, input logic [2:0] fi, input logic fd,
                        input logic fe, input logic [2:0] fm,
                        input logic irq, input logic ien);
        logic [2:0] fs [5];
        bit cp [5];
        logic [3:0] cc [5];
        bit ef;
        logic [3:0] ec;
        string tag;
        mv[0]  = nv;
        mpc[0] = next_pc;
        mp[0]  = 1'b0;
        mc[0]  = 4'd0;
        if (nv) next_pc = next_pc + 32'd4;
        @(negedge clk);
        stage_valid = {mv[4], mv[3], mv[2], mv[1], mv[0]};
        wb_pc     = mv[4] ? mpc[4] : 32'hDEAD_0000;
        if_fault  = fi; id_fault = fd; ex_fault = fe; mem_fault = fm;
        irq_req   = irq; irq_en = ien;
        #1;
        fs[0] = fi; fs[1] = {2'b0, fd}; fs[2] = {2'b0, fe}; fs[3] = fm; fs[4] = 3'b0;
        for (int s = 0; s < 5; s++) begin
            cc[s] = mp[s] ? mc[s] : strobe_cause(s, fs[s]);
            cp[s] = mv[s] && (mp[s] || strobe_cause(s, fs[s]) != 4'd0);
        end
        ef = mv[4] && (mp[4] || (irq && ien));
        ec = !ef ? 4'd0 : (mp[4] ? mc[4] : 4'd9);
        tag = (ec == 4'd9 || (irq && !mp[4])) ? "R11" : "R6";
        o_flush = 32'(flush); o_cause = 32'(exc_cause); o_pc = exc_pc;
        o_mk = 32'(mem_wr_kill); o_wk = 32'(wb_wr_kill);
        check(tag,  "flush", o_flush, 32'(ef));
        check("R2", "cause", o_cause, 32'(ec));
        check("R10", "exc_pc", o_pc, ef ? mpc[4] : 32'h0);
        check("R8", "mem_wr_kill", o_mk, 32'(ef || cp[3]));
        check("R9", "wb_wr_kill", o_wk, 32'(ef));
        if (ef) begin
            for (int s = 1; s < 5; s++) begin
                mv[s] = 1'b0; mp[s] = 1'b0; mc[s] = 4'd0;
            end
        end else begin
            for (int s = 4; s >= 1; s--) begin
                mv[s] = mv[s-1]; mpc[s] = mpc[s-1]; mp[s] = cp[s-1]; mc[s] = cc[s-1];
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'b0, 1'b0, 1'b0, 3'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa;
        void'($urandom(32'd4242));
        for (int s = 0; s < 5; s++) begin
            mv[s] = 0; mpc[s] = 0; mp[s] = 0; mc[s] = 0;
        end
        // R1: reset state, even with strobes and an interrupt present
        if_fault = 3'b111; irq_req = 1'b1; irq_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "flush in reset", 32'(flush), 0);
        check("R1", "cause in reset", 32'(exc_cause), 0);
        check("R1", "wb kill in reset", 32'(wb_wr_kill), 0);
        rst_n = 1'b1;
        if_fault = 3'b0; irq_req = 1'b0; irq_en = 1'b0;
        idle(2);
        check("R1", "idle flush", o_flush, 0);
        check("R1", "idle mem kill", o_mk, 0);

        // R3: misaligned and protection together -> misaligned (2)
        pa = next_pc;
        step(1, 3'b110, 0, 0, 3'b0, 0, 0);
        idle(3);
        check("R8", "mem kill for own fault", o_mk, 1);
        idle(1);
        check("R3", "intra-stage priority cause", o_cause, 2);
        check("R10", "trap pc", o_pc, pa);
        check("R5", "flush at write-back", o_flush, 1);
        idle(1);
        check("R5", "flush single cycle", o_flush, 0);

        // R4: fetch page fault then illegal opcode on same instruction
        pa = next_pc;
        step(1, 3'b001, 0, 0, 3'b0, 0, 0);
        step(0, 3'b0, 1, 0, 3'b0, 0, 0);
        step(0, 3'b0, 0, 1, 3'b0, 0, 0);
        step(0, 3'b0, 0, 0, 3'b100, 0, 0);
        idle(1);
        check("R4", "first cause kept", o_cause, 1);
        check("R4", "first cause pc", o_pc, pa);

        // R6/R12: younger faults first (fetch), older faults later (memory)
        pa = next_pc;
        step(1, 3'b0, 0, 0, 3'b0, 0, 0);        // A in IF
        step(1, 3'b001, 0, 0, 3'b0, 0, 0);      // B in IF faults, A in ID
        step(1, 3'b0, 0, 1, 3'b0, 0, 0);        // C in IF, B ID, A EX: ex strobe on A? no: A in EX
        // A now carries arithmetic cause 5 (older than B)
        step(0, 3'b0, 0, 0, 3'b0, 0, 0);        // A in MEM
        step(0, 3'b0, 0, 0, 3'b0, 0, 0);        // A in WB
        check("R6", "older instruction wins", o_cause, 5);
        check("R6", "older instruction pc", o_pc, pa);
        idle(6);
        check("R12", "younger record discarded", o_flush, 0);

        // R6: memory fault on older and execute fault on younger in same cycle
        pa = next_pc;
        step(1, 3'b0, 0, 0, 3'b0, 0, 0);
        step(1, 3'b0, 0, 0, 3'b0, 0, 0);
        step(0, 3'b0, 0, 0, 3'b0, 0, 0);
        step(0, 3'b0, 0, 1, 3'b010, 0, 0);      // A MEM misaligned, B EX arith
        step(0, 3'b0, 0, 0, 3'b0, 0, 0);
        check("R6", "same-cycle older wins", o_cause, 7);
        check("R6", "same-cycle pc", o_pc, pa);
        idle(5);
        check("R12", "after flush quiet", o_flush, 0);

        // R7: strobes on an empty pipeline record nothing
        step(0, 3'b111, 1, 1, 3'b111, 0, 0);
        check("R7", "bubble mem kill", o_mk, 0);
        idle(5);
        check("R7", "bubble never reports", o_flush, 0);

        // R11: masked interrupt, bubble interrupt, enabled interrupt
        step(1, 3'b0, 0, 0, 3'b0, 1, 0);
        idle(3);
        pa = mpc[4];
        step(0, 3'b0, 0, 0, 3'b0, 1, 0);
        check("R11", "masked irq ignored", o_flush, 0);
        step(0, 3'b0, 0, 0, 3'b0, 1, 1);
        check("R11", "irq on bubble ignored", o_flush, 0);
        pa = next_pc;
        step(1, 3'b0, 0, 0, 3'b0, 0, 0);
        idle(3);
        step(0, 3'b0, 0, 0, 3'b0, 1, 1);
        check("R11", "irq cause", o_cause, 9);
        check("R11", "irq pc", o_pc, pa);
        // fault wins over interrupt on same instruction
        step(1, 3'b0, 1, 0, 3'b0, 0, 0);
        step(0, 3'b0, 1, 0, 3'b0, 0, 0);
        idle(2);
        step(0, 3'b0, 0, 0, 3'b0, 1, 1);
        check("R11", "fault beats irq", o_cause, 4);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] fi, fm;
            logic fd, fe, irq, ien;
            fi  = {($urandom % 24 == 0), ($urandom % 24 == 0), ($urandom % 24 == 0)};
            fm  = {($urandom % 24 == 0), ($urandom % 24 == 0), ($urandom % 24 == 0)};
            fd  = ($urandom % 20 == 0);
            fe  = ($urandom % 20 == 0);
            irq = ($urandom % 30 == 0);
            ien = $urandom % 2;
            step(($urandom % 4) != 0, fi, fd, fe, fm, irq, ien);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule